// File: doc/BRIEF.md
# Vector XOR-and-Rotate Unit

This unit takes a 128-bit destination vector and a 128-bit source vector, combines them with a bitwise exclusive-or, and rotates every element of the combined vector to the right. Both the element width and the rotation distance come from instruction fields. A 4-bit width code is built from two 2-bit instruction fields, and a 3-bit immediate is appended below it. The unit decodes both values from this packed field, so instruction decode only has to forward raw bits.

The operation is destructive. The destination vector is an operand, and the result replaces it at writeback. No predication is applied: every element of the vector is written. When the width code is reserved, the unit raises an illegal flag and returns an all-zero vector in place of a result. One operation is accepted per cycle. Its result is registered and is presented together with a one-cycle valid pulse.

Top module: `xor_rotate_unit`

## Requirements
- R1: The width code is `{size_hi_i, size_lo_i}`, with `size_hi_i` in bits 3:2. A code of 0 is reserved: `illegal_o` is 1 and `result_o` is all zeros. Any nonzero code leaves `illegal_o` at 0.
- R2: Width code 4'b0001 selects 8-bit elements (16 lanes).
- R3: Width codes 4'b001x select 16-bit elements (8 lanes).
- R4: Width codes 4'b01xx select 32-bit elements (4 lanes).
- R5: Width codes 4'b1xxx select 64-bit elements (2 lanes).
- R6: The right-rotation distance equals 2*W minus the 7-bit value `{code, imm_i}`, where W is the element width in bits. This gives a distance from 1 to W.
- R7: A distance equal to W, which occurs when `{code, imm_i}` equals W, returns the unrotated XOR of the two elements.
- R8: Result element n is the rotation right of `dst_i` element n XOR `src_i` element n. Element n occupies bits `[n*W +: W]`.
- R9: `valid_o` is high in exactly the cycle after each cycle in which `valid_i` is high. `result_o` and `illegal_o` change at the same edge.
- R10: When `valid_i` is low, `result_o` and `illegal_o` hold their values, whatever the data and field inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| dst_i | input | 128 | Old destination vector |
| src_i | input | 128 | Source vector |
| size_hi_i | input | 2 | Upper half of the width code |
| size_lo_i | input | 2 | Lower half of the width code |
| imm_i | input | 3 | Immediate that sits below the width code |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 128 | Rotated XOR vector |
| illegal_o | output | 1 | Reserved width code seen |

## Verification
Every output is due exactly one rising edge after the cycle in which `valid_i` is sampled high. The bench drives each operation on a falling edge and drops the strobe on the next falling edge. It then reads `valid_o`, `result_o` and `illegal_o` at that same falling edge, which lies half a period after the edge that registered them. The bench reads `valid_o` again one falling edge later to confirm that the pulse has ended. For the hold checks, the bench changes the data and field inputs with the strobe low and samples two falling edges later.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int unsigned DATA_W = 128;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned IMM_W  = 3;
  localparam int unsigned NUM_EW = 4;
  localparam int unsigned ROT_W  = 6;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elem_w_e;
endpackage

// File: rtl/xr_field_dec.sv
module xr_field_dec
  import xr_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [IMM_W-1:0]  imm_i,
  output elem_w_e           ew_o,
  output logic [ROT_W-1:0]  rot_o,
  output logic              illegal_o
);
  // 2*W mod 64 per width; the rotation is taken mod 64, and the lanes reduce it further
  logic [ROT_W-1:0] two_w;
  logic [ROT_W-1:0] packed_lo;

  always_comb begin
    illegal_o = 1'b0;
    ew_o      = EW_8;
    two_w     = ROT_W'(16);
    casez (code_i)
      4'b1???: begin ew_o = EW_64; two_w = '0;           end
      4'b01??: begin ew_o = EW_32; two_w = '0;           end
      4'b001?: begin ew_o = EW_16; two_w = ROT_W'(32);   end
      4'b0001: begin ew_o = EW_8;  two_w = ROT_W'(16);   end
      default: illegal_o = 1'b1;
    endcase
  end

  assign packed_lo = {code_i[2:0], imm_i};
  assign rot_o     = two_w - packed_lo;
endmodule

// File: rtl/xr_rot_lane.sv
module xr_rot_lane #(
  parameter int unsigned W  = 8,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  y_o
);
  logic [2*W-1:0] dbl;
  // distance W arrives as 0 here, so the shift never goes out of range
  assign dbl = {x_i, x_i} >> amt_i;
  assign y_o = dbl[W-1:0];
endmodule

// File: rtl/xor_rotate_unit.sv
module xor_rotate_unit
  import xr_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic [1:0]    size_hi_i,
  input  logic [1:0]    size_lo_i,
  input  logic [2:0]    imm_i,
  output logic          valid_o,
  output logic [DW-1:0] result_o,
  output logic          illegal_o
);
  elem_w_e                      ew;
  logic [ROT_W-1:0]             rot;
  logic                         ill;
  logic [DW-1:0]                xv;
  logic [NUM_EW-1:0][DW-1:0]    rot_res;
  logic [DW-1:0]                res_d;

  xr_field_dec u_dec (
    .code_i    ({size_hi_i, size_lo_i}),
    .imm_i     (imm_i),
    .ew_o      (ew),
    .rot_o     (rot),
    .illegal_o (ill)
  );

  assign xv = dst_i ^ src_i;

  for (genvar k = 0; k < NUM_EW; k++) begin : g_width
    localparam int unsigned W  = 8 << k;
    localparam int unsigned AW = $clog2(W);
    for (genvar e = 0; e < DW / W; e++) begin : g_lane
      xr_rot_lane #(.W(W)) u_lane (
        .x_i   (xv[e*W +: W]),
        .amt_i (rot[AW-1:0]),
        .y_o   (rot_res[k][e*W +: W])
      );
    end
  end

  always_comb begin
    unique case (ew)
      EW_8:    res_d = rot_res[0];
      EW_16:   res_d = rot_res[1];
      EW_32:   res_d = rot_res[2];
      default: res_d = rot_res[3];
    endcase
    if (ill) res_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        illegal_o <= ill;
      end
    end
  end
endmodule

// File: rtl/xr_checker.sv
module xr_checker #(
  parameter int unsigned DW = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] dst_i,
  input logic [DW-1:0] src_i,
  input logic [1:0]    size_hi_i,
  input logic [1:0]    size_lo_i,
  input logic          valid_o,
  input logic [DW-1:0] result_o,
  input logic          illegal_o
);
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_RESERVED_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && {size_hi_i, size_lo_i} == 4'd0) |=> (illegal_o && result_o == '0)); // R1
  AST_LEGAL_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && {size_hi_i, size_lo_i} != 4'd0) |=> !illegal_o); // R1
  AST_EQUAL_OPS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dst_i == src_i) |=> result_o == '0); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o))); // R10
endmodule

bind xor_rotate_unit xr_checker #(.DW(DW)) i_xr_checker (.*);

// File: tb/test_xor_rotate_unit.sv
`timescale 1ns/1ps
module test_xor_rotate_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] dst_i = '0, src_i = '0;
  logic [1:0]   size_hi_i = '0, size_lo_i = '0;
  logic [2:0]   imm_i = '0;
  logic         valid_o, illegal_o;
  logic [127:0] result_o;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  xor_rotate_unit i_xor_rotate_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .dst_i(dst_i), .src_i(src_i),
    .size_hi_i(size_hi_i), .size_lo_i(size_lo_i), .imm_i(imm_i),
    .valid_o(valid_o), .result_o(result_o), .illegal_o(illegal_o)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input logic [3:0] c);
    if (c[3]) return 64;
    if (c[2]) return 32;
    if (c[1]) return 16;
    if (c[0]) return 8;
    return 0;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] s,
                                         input logic [3:0] c, input logic [2:0] im);
    int w   = width_of(c);
    int amt = 2 * w - int'({c, im});
    logic [127:0] x = d ^ s;
    logic [127:0] r = '0;
    for (int e = 0; e < 128 / w; e++)
      for (int b = 0; b < w; b++)
        r[e*w + b] = x[e*w + ((b + amt) % w)];
    return r;
  endfunction

  task automatic run_op(input logic [127:0] d, input logic [127:0] s,
                        input logic [3:0] c, input logic [2:0] im);
    @(negedge clk);
    dst_i = d; src_i = s; size_hi_i = c[3:2]; size_lo_i = c[1:0]; imm_i = im;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [127:0] pats_d [3];
    logic [127:0] pats_s [3];
    logic [127:0] held;
    string tag;
    pats_d[0] = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    pats_s[0] = 128'h0000_0000_0000_0000_0000_0000_0000_0000;
    pats_d[1] = 128'h8000_0001_8000_0001_c3a5_5a3c_0f0f_f0f0;
    pats_s[1] = 128'h1111_2222_4444_8888_dead_beef_cafe_f00d;
    pats_d[2] = 128'hffff_ffff_0000_0000_a5a5_a5a5_5a5a_5a5a;
    pats_s[2] = 128'h0000_0001_8000_0000_0000_0001_0000_0080;

    repeat (2) @(negedge clk);
    check(valid_o == 1'b0 && illegal_o == 1'b0 && result_o == '0, "R9 reset state", result_o, '0);
    rst_n = 1'b1;

    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 16; c++) begin
        for (int im = 0; im < 8; im++) begin
          run_op(pats_d[p], pats_s[p], 4'(c), 3'(im));
          check(valid_o == 1'b1, "R9 valid pulse", {127'd0, valid_o}, 128'd1);
          if (c == 0) begin
            check(illegal_o == 1'b1, "R1 reserved flag", {127'd0, illegal_o}, 128'd1);
            check(result_o == '0, "R1 reserved result", result_o, '0);
          end else begin
            case (width_of(4'(c)))
              8:  tag = "R2 R6 R8 width 8";
              16: tag = "R3 R6 R8 width 16";
              32: tag = "R4 R6 R8 width 32";
              default: tag = "R5 R6 R8 width 64";
            endcase
            check(illegal_o == 1'b0, "R1 legal flag", {127'd0, illegal_o}, 128'd0);
            check(result_o == model(pats_d[p], pats_s[p], 4'(c), 3'(im)), tag,
                  result_o, model(pats_d[p], pats_s[p], 4'(c), 3'(im)));
          end
        end
      end
    end

    // distance equal to width: code whose packed value equals W
    for (int k = 0; k < 4; k++) begin
      run_op(pats_d[1], pats_s[1], 4'(1 << k), 3'd0);
      check(result_o == (pats_d[1] ^ pats_s[1]), "R7 full-width rotation", result_o, pats_d[1] ^ pats_s[1]);
    end

    @(negedge clk);
    check(valid_o == 1'b0, "R9 pulse ends", {127'd0, valid_o}, 128'd0);

    held = result_o;
    dst_i = ~dst_i; src_i = 128'h5; size_hi_i = 2'b00; size_lo_i = 2'b00; imm_i = 3'd5;
    repeat (2) @(negedge clk);
    check(result_o == held, "R10 hold result", result_o, held);
    check(illegal_o == 1'b0, "R10 hold flag", {127'd0, illegal_o}, 128'd0);

    finish_run();
  end
endmodule